// File: doc/BRIEF.md
# Serial-Wire Debug Port Transaction Controller

This block sits behind the bit-level front end of a two-wire debug port. Each request arrives already decoded: a port select (debug port or access port), a read/write flag, a two-bit register address and, for writes, a 32-bit word. One cycle later the block returns a three-bit acknowledge code and, for reads, a data word.

The block owns the debug-port registers:
- a fixed identification word
- an abort register
- control/status
- wire control
- a read-resend register
- a select register
- a read buffer

Access-port traffic goes to a downstream bus with a valid/ready request and a separate response strobe.

Reads on the access port are posted. Each one returns the result of the access-port read before it, and the downstream read it starts fills the read buffer later. Writes to either port go through a one-entry buffer. A buffered write takes effect only after the line has been idle for two cycles.

While the buffer holds a write, most requests are refused with WAIT. The identification read, the control/status read and the abort write are always served.

Top module: `swdp_access_ctrl`

## Requirements
- R1: Each request (req_valid high for one cycle) gets exactly one response in the following cycle: rsp_ack is 3'b001 for OK or 3'b010 for WAIT. A debug-port read at address 0 returns 0x2BA01477 with OK.
- R2: A debug-port write at address 2 loads select. Select bit 0 makes address 1 reach wire control (1) or control/status (0). Select bits [7:4] form the upper four bits of the downstream address, which is {bank, req_addr, 2'b00}.
- R3: An access-port read returns, with OK, the result of the previous access-port read (0 after reset). It then starts a downstream read whose result lands in the read buffer.
- R4: A debug-port read at address 3 returns the read buffer without starting any downstream access. A write to address 3 has no effect.
- R5: A debug-port read at address 2 returns the data of the most recent read that was answered OK.
- R6: Control/status bit 1 (read-ok) is updated on every OK access-port read and every OK read-buffer read. It is set to 1 if the result being returned came back without error. Bit 0 is a sticky error, set by any downstream response with error.
- R7: A write answered OK is held in the buffer. It commits once two cycles with line_idle high have passed after it was accepted, and its effect is not visible before that.
- R8: While the buffer is occupied, every request is answered WAIT except three: the address-0 read, the address-1 read with select bit 0 clear, and the address-0 write.
- R9: A debug-port write at address 0 (abort) clears the sticky error and discards a buffered write that has not yet committed.
- R10: Control/status bits 4 and 6 are writable power-up requests (debug and system). Bits 5 and 7 follow them as acknowledges one cycle after the write commits.
- R11: While a downstream transfer is in progress, an access-port read or a read-buffer read is answered WAIT. A downstream request holds its address and data until ready.
- R12: After reset, control/status, select, wire control, the read buffer and read-resend are all 0, and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Decoded request present this cycle |
| req_ap | input | 1 | 1 = access port, 0 = debug port |
| req_rnw | input | 1 | 1 = read, 0 = write |
| req_addr | input | 2 | Register address |
| req_wdata | input | 32 | Write data |
| line_idle | input | 1 | Line spent this cycle idle |
| rsp_valid | output | 1 | Response present |
| rsp_ack | output | 3 | Acknowledge code |
| rsp_rdata | output | 32 | Read data (0 for writes and WAIT) |
| ap_req_valid | output | 1 | Downstream request valid |
| ap_req_ready | input | 1 | Downstream request accepted |
| ap_req_write | output | 1 | Downstream request is a write |
| ap_req_addr | output | 8 | Downstream byte address |
| ap_req_wdata | output | 32 | Downstream write data |
| ap_rsp_valid | input | 1 | Downstream response strobe |
| ap_rsp_rdata | input | 32 | Downstream read data |
| ap_rsp_err | input | 1 | Downstream response error |

## Verification
The bench targets the posted-read offset. A design that returned the current access-port result instead of the previous one would shift every read value by one transfer.

It probes the commit point of a buffered write, with an exempt status read placed between the first and second idle cycles. Committing too early exposes the power-up bits there; never counting idle leaves them unset.

With the buffer full, it checks both the three exempt accesses and the WAIT on all others. It also checks that an abort really drops the pending write. Back-to-back access-port and read-buffer reads test the busy WAIT, and a read to a faulting bank exercises the sticky error and the read-ok flag.

// File: rtl/swdp_pkg.sv
// Package: shared codes and types for the debug-port transaction controller.
// Assumes a 3-bit acknowledge field with one-hot OK/WAIT codes.
package swdp_pkg;
    localparam logic [2:0] ACK_OK   = 3'b001;
    localparam logic [2:0] ACK_WAIT = 3'b010;

    localparam logic [1:0] DP_A_ID_ABORT = 2'd0;
    localparam logic [1:0] DP_A_CTRL     = 2'd1;
    localparam logic [1:0] DP_A_SEL_RS   = 2'd2;
    localparam logic [1:0] DP_A_RDBUF    = 2'd3;

    // Downstream bridge sequencing states.
    typedef enum logic [1:0] {
        BR_IDLE = 2'd0,
        BR_REQ  = 2'd1,
        BR_RESP = 2'd2
    } br_state_t;
endpackage

// File: rtl/swdp_wbuf.sv
// Module: single-entry write buffer with idle-cycle commit delay.
// Holds one accepted write and releases it once IDLE_CYC line-idle cycles
// have been seen after acceptance. An access-port entry also waits for the
// downstream bridge to be free. Assumes push never coincides with discard.
module swdp_wbuf #(
    parameter int DW       = 32,
    parameter int IDLE_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          push_ap,
    input  logic [1:0]    push_a,
    input  logic [DW-1:0] push_wdata,
    input  logic          line_idle,
    input  logic          discard,
    input  logic          ap_sink_free,
    output logic          full,
    output logic          commit,
    output logic          commit_ap,
    output logic [1:0]    commit_a,
    output logic [DW-1:0] commit_wdata
);
    localparam int CW = $clog2(IDLE_CYC + 1);
    localparam logic [CW-1:0] CNT_DONE = CW'(IDLE_CYC);

    logic [CW-1:0] idle_cnt;
    logic          delay_met;

    // Entry is due once enough idle cycles were counted.
    assign delay_met    = full && (idle_cnt == CNT_DONE);
    assign commit       = delay_met && (!commit_ap || ap_sink_free);

    // Entry storage, idle counter and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full         <= 1'b0;
            idle_cnt     <= '0;
            commit_ap    <= 1'b0;
            commit_a     <= '0;
            commit_wdata <= '0;
        end else if (discard) begin
            full     <= 1'b0;
            idle_cnt <= '0;
        end else if (push) begin
            full         <= 1'b1;
            idle_cnt     <= '0;
            commit_ap    <= push_ap;
            commit_a     <= push_a;
            commit_wdata <= push_wdata;
        end else if (commit) begin
            full     <= 1'b0;
            idle_cnt <= '0;
        end else if (full && line_idle && (idle_cnt != CNT_DONE)) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    // R8: the buffer never takes a second write while occupied.
    a_r8_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R9: a discard leaves the buffer empty.
    a_r9_discard_empties: assert property (@(posedge clk) disable iff (!rst_n)
        discard |=> !full);
    // R7: a commit only happens on an entry that was already held.
    a_r7_commit_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(full));
endmodule

// File: rtl/swdp_apbridge.sv
// Module: downstream access-port bridge with posted read buffer.
// Runs one transfer at a time: raise a request, hold it until ready, then
// wait for the response strobe. Read results land in the read buffer with
// their error status. Assumes one response per accepted request.
module swdp_apbridge
    import swdp_pkg::*;
#(
    parameter int DW    = 32,
    parameter int AP_AW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_rd,
    input  logic             start_wr,
    input  logic [AP_AW-1:0] start_addr,
    input  logic [DW-1:0]    start_wdata,
    output logic             dn_valid,
    input  logic             dn_ready,
    output logic             dn_write,
    output logic [AP_AW-1:0] dn_addr,
    output logic [DW-1:0]    dn_wdata,
    input  logic             dn_rsp_valid,
    input  logic [DW-1:0]    dn_rsp_rdata,
    input  logic             dn_rsp_err,
    output logic             busy,
    output logic [DW-1:0]    post_data,
    output logic             post_err,
    output logic             err_evt
);
    br_state_t state;

    assign busy     = (state != BR_IDLE);
    assign dn_valid = (state == BR_REQ);
    assign err_evt  = (state == BR_RESP) && dn_rsp_valid && dn_rsp_err;

    // Transfer sequencing and request capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= BR_IDLE;
            dn_write <= 1'b0;
            dn_addr  <= '0;
            dn_wdata <= '0;
        end else begin
            case (state)
                BR_IDLE: if (start_rd || start_wr) begin
                    state    <= BR_REQ;
                    dn_write <= start_wr;
                    dn_addr  <= start_addr;
                    dn_wdata <= start_wr ? start_wdata : '0;
                end
                BR_REQ:  if (dn_ready) state <= BR_RESP;
                BR_RESP: if (dn_rsp_valid) state <= BR_IDLE;
                default: state <= BR_IDLE;
            endcase
        end
    end

    // Posted read result and its error status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            post_data <= '0;
            post_err  <= 1'b0;
        end else if ((state == BR_RESP) && dn_rsp_valid && !dn_write) begin
            post_data <= dn_rsp_rdata;
            post_err  <= dn_rsp_err;
        end
    end

    // R11: a stalled request keeps its address and data.
    a_r11_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_addr) && $stable(dn_wdata)));
    // R11: no new transfer is started while one is in progress.
    a_r11_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start_rd || start_wr) |-> !busy);
endmodule

// File: rtl/swdp_dpregs.sv
// Module: debug-port register file (control/status, select, wire control,
// read-resend). Applies committed writes, sticky error, read-ok and
// power-up acknowledge mirroring. Assumes writes arrive only via commit.
module swdp_dpregs
    import swdp_pkg::*;
#(
    parameter int DW     = 32,
    parameter int BANK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_a,
    input  logic [DW-1:0]     wr_data,
    input  logic              abort,
    input  logic              err_evt,
    input  logic              rok_upd,
    input  logic              rok_val,
    input  logic              rs_load,
    input  logic [DW-1:0]     rs_val,
    output logic [DW-1:0]     ctrlstat,
    output logic [DW-1:0]     wirectl,
    output logic              ctrlsel,
    output logic [BANK_W-1:0] bank,
    output logic [DW-1:0]     resend
);
    localparam int BIT_DBG_REQ = 4;
    localparam int BIT_SYS_REQ = 6;

    logic [DW-1:0] select_q;
    logic sticky_err, read_ok;
    logic dbg_req, dbg_ack, sys_req, sys_ack;

    assign ctrlsel = select_q[0];
    assign bank    = select_q[4 +: BANK_W];

    // Assemble the control/status word.
    always_comb begin
        ctrlstat    = '0;
        ctrlstat[0] = sticky_err;
        ctrlstat[1] = read_ok;
        ctrlstat[4] = dbg_req;
        ctrlstat[5] = dbg_ack;
        ctrlstat[6] = sys_req;
        ctrlstat[7] = sys_ack;
    end

    // Committed register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            select_q <= '0;
            wirectl  <= '0;
            dbg_req  <= 1'b0;
            sys_req  <= 1'b0;
        end else if (wr_en) begin
            case (wr_a)
                DP_A_CTRL: begin
                    if (select_q[0]) begin
                        wirectl <= wr_data;
                    end else begin
                        dbg_req <= wr_data[BIT_DBG_REQ];
                        sys_req <= wr_data[BIT_SYS_REQ];
                    end
                end
                DP_A_SEL_RS: select_q <= wr_data;
                default: ;
            endcase
        end
    end

    // Power-up acknowledges follow their requests by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dbg_ack <= 1'b0;
            sys_ack <= 1'b0;
        end else begin
            dbg_ack <= dbg_req;
            sys_ack <= sys_req;
        end
    end

    // Sticky error: set by downstream errors, cleared by abort.
    always_ff @(posedge clk) begin
        if (!rst_n)       sticky_err <= 1'b0;
        else if (err_evt) sticky_err <= 1'b1;
        else if (abort)   sticky_err <= 1'b0;
    end

    // Read-ok flag and read-resend capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            read_ok <= 1'b0;
            resend  <= '0;
        end else begin
            if (rok_upd) read_ok <= rok_val;
            if (rs_load) resend  <= rs_val;
        end
    end

    // R9: abort without a coincident error leaves the sticky flag clear.
    a_r9_abort_clears_err: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && !err_evt) |=> !ctrlstat[0]);
    // R6: a downstream error always leaves the sticky flag set.
    a_r6_err_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        err_evt |=> ctrlstat[0]);
endmodule

// File: rtl/swdp_access_ctrl.sv
// Module: top of the debug-port transaction layer. Decodes requests,
// decides OK/WAIT, steers reads, feeds the write buffer and the downstream
// bridge, and registers a response one cycle after each request.
// Assumes requests arrive already decoded, at most one per cycle.
module swdp_access_ctrl
    import swdp_pkg::*;
#(
    parameter int          DW       = 32,
    parameter int          BANK_W   = 4,
    parameter int          IDLE_CYC = 2,
    parameter logic [31:0] ID_WORD  = 32'h2BA0_1477,
    localparam int         AP_AW    = BANK_W + 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_ap,
    input  logic             req_rnw,
    input  logic [1:0]       req_addr,
    input  logic [DW-1:0]    req_wdata,
    input  logic             line_idle,
    output logic             rsp_valid,
    output logic [2:0]       rsp_ack,
    output logic [DW-1:0]    rsp_rdata,
    output logic             ap_req_valid,
    input  logic             ap_req_ready,
    output logic             ap_req_write,
    output logic [AP_AW-1:0] ap_req_addr,
    output logic [DW-1:0]    ap_req_wdata,
    input  logic             ap_rsp_valid,
    input  logic [DW-1:0]    ap_rsp_rdata,
    input  logic             ap_rsp_err
);
    logic id_rd, abort_wr, cs_rd, rdbuf_rd, ap_rd, exempt, stall;
    logic go, push, abort, start_rd;
    logic wb_full, wb_commit, wb_ap;
    logic [1:0] wb_a;
    logic [DW-1:0] wb_wdata;
    logic br_busy, post_err, err_evt;
    logic [DW-1:0] post_data, ctrlstat, wirectl, resend, rd_word;
    logic ctrlsel;
    logic [BANK_W-1:0] bank;

    // Classify the incoming request.
    always_comb begin
        id_rd    = !req_ap &&  req_rnw && (req_addr == DP_A_ID_ABORT);
        abort_wr = !req_ap && !req_rnw && (req_addr == DP_A_ID_ABORT);
        cs_rd    = !req_ap &&  req_rnw && (req_addr == DP_A_CTRL) && !ctrlsel;
        rdbuf_rd = !req_ap &&  req_rnw && (req_addr == DP_A_RDBUF);
        ap_rd    =  req_ap &&  req_rnw;
        exempt   = id_rd || cs_rd || abort_wr;
        stall    = (wb_full && !exempt) || ((ap_rd || rdbuf_rd) && br_busy);
    end

    assign go       = req_valid && !stall;
    assign push     = go && !req_rnw && !abort_wr;
    assign abort    = go && abort_wr;
    assign start_rd = go && ap_rd;

    // Select the word a read returns.
    always_comb begin
        if (req_ap) begin
            rd_word = post_data;
        end else begin
            case (req_addr)
                DP_A_ID_ABORT: rd_word = ID_WORD;
                DP_A_CTRL:     rd_word = ctrlsel ? wirectl : ctrlstat;
                DP_A_SEL_RS:   rd_word = resend;
                default:       rd_word = post_data;
            endcase
        end
    end

    // One registered response per request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_ack   <= ACK_OK;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_ack   <= stall ? ACK_WAIT : ACK_OK;
            rsp_rdata <= (go && req_rnw) ? rd_word : '0;
        end
    end

    swdp_wbuf #(.DW(DW), .IDLE_CYC(IDLE_CYC)) u_wbuf (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_ap(req_ap), .push_a(req_addr), .push_wdata(req_wdata),
        .line_idle(line_idle), .discard(abort), .ap_sink_free(!br_busy),
        .full(wb_full), .commit(wb_commit), .commit_ap(wb_ap),
        .commit_a(wb_a), .commit_wdata(wb_wdata)
    );

    swdp_apbridge #(.DW(DW), .AP_AW(AP_AW)) u_bridge (
        .clk(clk), .rst_n(rst_n),
        .start_rd(start_rd), .start_wr(wb_commit && wb_ap),
        .start_addr(start_rd ? {bank, req_addr, 2'b00} : {bank, wb_a, 2'b00}),
        .start_wdata(wb_wdata),
        .dn_valid(ap_req_valid), .dn_ready(ap_req_ready), .dn_write(ap_req_write),
        .dn_addr(ap_req_addr), .dn_wdata(ap_req_wdata),
        .dn_rsp_valid(ap_rsp_valid), .dn_rsp_rdata(ap_rsp_rdata), .dn_rsp_err(ap_rsp_err),
        .busy(br_busy), .post_data(post_data), .post_err(post_err), .err_evt(err_evt)
    );

    swdp_dpregs #(.DW(DW), .BANK_W(BANK_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wb_commit && !wb_ap), .wr_a(wb_a), .wr_data(wb_wdata),
        .abort(abort), .err_evt(err_evt),
        .rok_upd(go && (ap_rd || rdbuf_rd)), .rok_val(!post_err),
        .rs_load(go && req_rnw), .rs_val(rd_word),
        .ctrlstat(ctrlstat), .wirectl(wirectl), .ctrlsel(ctrlsel),
        .bank(bank), .resend(resend)
    );

    // R1: identification read answers OK with the fixed word.
    a_r1_idcode: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ap && req_rnw && (req_addr == 2'd0))
        |=> (rsp_ack == ACK_OK && rsp_rdata == ID_WORD));
    // R8: abort writes are never refused.
    a_r8_abort_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ap && !req_rnw && (req_addr == 2'd0)) |=> (rsp_ack == ACK_OK));
    // R1: every response carries exactly one acknowledge code.
    a_r1_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones(rsp_ack) == 1));
    // R1: a response follows each request in the next cycle.
    a_r1_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
endmodule

// File: tb/tb_swdp_access_ctrl.sv
module tb_swdp_access_ctrl;
    localparam logic [2:0] OK = 3'b001;
    localparam logic [2:0] WT = 3'b010;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_ap = 1'b0, req_rnw = 1'b0, line_idle = 1'b0;
    logic [1:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic rsp_valid;
    logic [2:0] rsp_ack;
    logic [31:0] rsp_rdata;
    logic ap_req_valid, ap_req_write;
    logic [7:0] ap_req_addr;
    logic [31:0] ap_req_wdata;
    logic ap_rsp_valid = 1'b0, ap_rsp_err = 1'b0;
    logic [31:0] ap_rsp_rdata = '0;
    logic [31:0] mem [64];
    int n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    swdp_access_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ap(req_ap),
        .req_rnw(req_rnw), .req_addr(req_addr), .req_wdata(req_wdata),
        .line_idle(line_idle), .rsp_valid(rsp_valid), .rsp_ack(rsp_ack),
        .rsp_rdata(rsp_rdata), .ap_req_valid(ap_req_valid), .ap_req_ready(1'b1),
        .ap_req_write(ap_req_write), .ap_req_addr(ap_req_addr),
        .ap_req_wdata(ap_req_wdata), .ap_rsp_valid(ap_rsp_valid),
        .ap_rsp_rdata(ap_rsp_rdata), .ap_rsp_err(ap_rsp_err)
    );

    // Downstream memory model: always ready, response one cycle later,
    // error on bank 0xF. Word i starts as 0x10000000 + i.
    initial for (int i = 0; i < 64; i++) mem[i] = 32'h1000_0000 + i;
    always @(posedge clk) begin
        if (ap_req_valid) begin
            if (ap_req_write) mem[ap_req_addr[7:2]] <= ap_req_wdata;
            ap_rsp_rdata <= mem[ap_req_addr[7:2]];
            ap_rsp_err   <= (ap_req_addr[7:4] == 4'hF);
            ap_rsp_valid <= 1'b1;
        end else begin
            ap_rsp_valid <= 1'b0;
        end
    end

    typedef struct packed {
        logic ap; logic rnw; logic [1:0] a; logic [31:0] wd;
        logic [3:0] gap; logic gidle; logic [2:0] eack; logic [31:0] ed; logic [3:0] rq;
    } vec_t;
    localparam int NV = 21;
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b1,2'd0,32'h0,        4'd2,1'b0,OK,32'h2BA01477,4'd1},  // R1 id
        '{1'b0,1'b1,2'd1,32'h0,        4'd2,1'b0,OK,32'h0,       4'd12}, // R12 ctrl
        '{1'b1,1'b0,2'd1,32'hA5A50001, 4'd6,1'b1,OK,32'h0,       4'd7},  // R7 ap wr
        '{1'b1,1'b1,2'd1,32'h0,        4'd6,1'b0,OK,32'h0,       4'd3},  // R3 posted
        '{1'b1,1'b1,2'd2,32'h0,        4'd6,1'b0,OK,32'hA5A50001,4'd3},  // R3 prev
        '{1'b0,1'b1,2'd3,32'h0,        4'd2,1'b0,OK,32'h10000002,4'd4},  // R4 rdbuf
        '{1'b0,1'b1,2'd2,32'h0,        4'd2,1'b0,OK,32'h10000002,4'd5},  // R5 resend
        '{1'b0,1'b1,2'd1,32'h0,        4'd2,1'b0,OK,32'h00000002,4'd6},  // R6 readok
        '{1'b0,1'b0,2'd1,32'h50,       4'd6,1'b1,OK,32'h0,       4'd10}, // R10 pwr
        '{1'b0,1'b1,2'd1,32'h0,        4'd2,1'b0,OK,32'h000000F2,4'd10}, // R10 acks
        '{1'b0,1'b0,2'd2,32'hF0,       4'd4,1'b1,OK,32'h0,       4'd2},  // R2 bank F
        '{1'b1,1'b1,2'd0,32'h0,        4'd6,1'b0,OK,32'h10000002,4'd3},  // R3
        '{1'b0,1'b1,2'd3,32'h0,        4'd2,1'b0,OK,32'h1000003C,4'd2},  // R2 addr F0
        '{1'b0,1'b1,2'd1,32'h0,        4'd2,1'b0,OK,32'h000000F1,4'd6},  // R6 err
        '{1'b0,1'b0,2'd0,32'h0,        4'd2,1'b0,OK,32'h0,       4'd9},  // R9 abort
        '{1'b0,1'b1,2'd1,32'h0,        4'd2,1'b0,OK,32'h000000F0,4'd9},  // R9 cleared
        '{1'b0,1'b0,2'd2,32'h01,       4'd4,1'b1,OK,32'h0,       4'd2},  // R2 ctrlsel
        '{1'b0,1'b0,2'd1,32'hC3,       4'd4,1'b1,OK,32'h0,       4'd2},  // R2 wirectl
        '{1'b0,1'b1,2'd1,32'h0,        4'd2,1'b0,OK,32'h000000C3,4'd2},  // R2
        '{1'b0,1'b0,2'd2,32'h00,       4'd4,1'b1,OK,32'h0,       4'd2},  // R2
        '{1'b0,1'b1,2'd1,32'h0,        4'd2,1'b0,OK,32'h000000F0,4'd2}   // R2
    };

    // Issue one request at a negedge; check its response one cycle later.
    task automatic xfer(input logic ap, input logic rnw, input logic [1:0] a,
                        input logic [31:0] wd, input logic [2:0] eack,
                        input logic [31:0] ed, input string tag);
        req_valid = 1'b1; req_ap = ap; req_rnw = rnw; req_addr = a; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n_chk++;
        if (rsp_valid !== 1'b1 || rsp_ack !== eack || rsp_rdata !== ed) begin
            n_bad++;
            $display("FAIL %s: got valid=%b ack=%b data=%h, expected ack=%b data=%h",
                     tag, rsp_valid, rsp_ack, rsp_rdata, eack, ed);
        end
    endtask

    task automatic gap(input int n, input logic idle);
        for (int k = 0; k < n; k++) begin
            line_idle = idle;
            @(negedge clk);
        end
        line_idle = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run hung (R1 response path)");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        for (int i = 0; i < NV; i++) begin
            xfer(VEC[i].ap, VEC[i].rnw, VEC[i].a, VEC[i].wd, VEC[i].eack, VEC[i].ed,
                 $sformatf("vec%0d R%0d", i, VEC[i].rq));
            gap(int'(VEC[i].gap), VEC[i].gidle);
        end

        // R12: reset state through the normal interface.
        do_reset();
        xfer(0,1,2'd1,0,OK,32'h0,"R12 ctrlstat");
        xfer(0,1,2'd3,0,OK,32'h0,"R12 rdbuf");
        xfer(0,1,2'd2,0,OK,32'h0,"R12 resend");
        xfer(0,0,2'd2,32'h1,OK,32'h0,"R12 sel"); gap(4,1);
        xfer(0,1,2'd1,0,OK,32'h0,"R12 wirectl");
        xfer(0,0,2'd2,32'h0,OK,32'h0,"R12 sel0"); gap(4,1);

        // R7 / R10: commit needs two idle cycles; not visible after one.
        do_reset();
        xfer(0,0,2'd1,32'h10,OK,32'h0,"R7 wr"); gap(1,1);
        xfer(0,1,2'd1,0,OK,32'h0,"R7 before commit");
        gap(1,1); gap(3,0);
        xfer(0,1,2'd1,0,OK,32'h30,"R10 after commit");

        // R11: busy downstream causes WAIT.
        do_reset();
        xfer(1,1,2'd1,0,OK,32'h0,"R11 first read");
        xfer(1,1,2'd1,0,WT,32'h0,"R11 back-to-back");
        gap(6,0);
        xfer(0,1,2'd3,0,OK,32'hA5A50001,"R11 rdbuf");
        xfer(1,1,2'd2,0,OK,32'hA5A50001,"R11 read2");
        xfer(0,1,2'd3,0,WT,32'h0,"R11 rdbuf busy");
        gap(6,0);
        xfer(0,1,2'd3,0,OK,32'h10000002,"R11 rdbuf later");

        // R4: writing the read-buffer address changes nothing.
        xfer(0,0,2'd3,32'hDEADBEEF,OK,32'h0,"R4 wr"); gap(4,1);
        xfer(0,1,2'd3,0,OK,32'h10000002,"R4 unchanged");

        // R8 / R9: full buffer WAITs except the exempt three; abort discards.
        do_reset();
        xfer(0,0,2'd1,32'h40,OK,32'h0,"R8 fill");
        xfer(0,1,2'd2,0,WT,32'h0,"R8 resend wait");
        xfer(0,1,2'd0,0,OK,32'h2BA01477,"R8 id exempt");
        xfer(0,1,2'd1,0,OK,32'h0,"R8 ctrl exempt");
        xfer(1,1,2'd0,0,WT,32'h0,"R8 ap wait");
        xfer(0,0,2'd2,32'h1,WT,32'h0,"R8 write wait");
        xfer(0,0,2'd0,32'h0,OK,32'h0,"R9 abort");
        gap(4,1);
        xfer(0,1,2'd1,0,OK,32'h0,"R9 discarded");
        xfer(0,0,2'd1,32'h40,OK,32'h0,"R9 empty again");

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule